// File: doc/BRIEF.md
# Clause 22 MDIO Management Master

This block lets software reach the management registers of external PHYs over a two-wire MDIO/MDC bus. It has one 32-bit command/status word. A single write to that word supplies the PHY address, the register number, the direction and, for a write, the data. The block then produces the MDC clock and shifts out a complete Clause 22 frame. It controls the MDIO output enable itself, so a tri-state pad can sit outside the block.

While a frame is on the wire, a busy flag in the command word stays set. When a read finishes, the captured 16 bits appear in the low half of the same word and a read-valid flag is raised. Every completed frame also sets a completion cause bit. Software clears that bit by writing zero to it, and can mask it before it reaches the interrupt output. MDC runs at the system clock divided by 2*CLK_DIV.

Top module: `mdio_cmd_master`

## Requirements
- R1: After reset, all three registers read zero, `mdc`, `mdio_oe` and `irq` are low.
- R2: A write to offset 0x00 while idle is accepted, and busy (bit 28) reads one on the next cycle. The command word fields are: data in bits 15:0, PHY address in bits 20:16, register number in bits 25:21, and bit 26 = 1 for a read, 0 for a write.
- R3: A write frame is driven MSB first as 32 ones, start 01, opcode 01, PHY address, register number, turnaround 10, then 16 data bits. MDIO changes only after the falling edge of MDC.
- R4: A read frame sends opcode 10 and releases MDIO (`mdio_oe` low) from the first turnaround bit onward. It samples `mdio_i` on the rising edge of MDC. It then returns the 16 data bits in bits 15:0 with read-valid (bit 27) set.
- R5: Busy clears exactly 128*CLK_DIV clock cycles after the command is accepted.
- R6: A command write while busy is ignored: the fields read back and the frame on the wire are those of the first command.
- R7: Read-valid clears when a new command is accepted, and stays clear after a write frame.
- R8: Bit 4 of the cause register at offset 0x7C is set when a frame completes. Writing 0 to bit 4 clears it; writing 1 there leaves it unchanged. If completion and a clearing write fall in the same cycle, the bit ends set.
- R9: Bit 4 of the mask register at offset 0x80 gates the cause bit: `irq` is high exactly when both bits are one.
- R10: While idle, MDC is held low and MDIO is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Byte offset of the register access |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | MDIO value when driven |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value seen at the pad |
| irq | output | 1 | Completion interrupt |

## Verification
Frame completion and a software write-to-clear of the cause bit can land on the same clock edge. The bench provokes this from the known frame length. It places a zero write to offset 0x7C exactly 128*CLK_DIV cycles after the command was accepted. It passes if the cause bit reads one afterwards and `irq` follows the mask.

A second overlap is a new command written in the cycles while a frame is still running. It is judged by checking that the bus frame and the readback fields belong only to the first command.

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master #(
  parameter int CLK_DIV = 20,
  parameter int AW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic          mdc,
  output logic          mdio_o,
  output logic          mdio_oe,
  input  logic          mdio_i,
  output logic          irq
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] CNT_END = CW'(CLK_DIV - 1);
  localparam logic [AW-1:0] OFS_CMD   = AW'(8'h00);
  localparam logic [AW-1:0] OFS_CAUSE = AW'(8'h7C);
  localparam logic [AW-1:0] OFS_MASK  = AW'(8'h80);

  logic          busy, rvalid, rd_op, mdc_q, smp, cause, mask;
  logic [4:0]    phy, regn;
  logic [15:0]   data;
  logic [63:0]   sh;
  logic [5:0]    bitn;
  logic [CW-1:0] cnt;

  wire cmd_go = wr_en && addr == OFS_CMD && !busy;
  wire tick   = busy && cnt == CNT_END;
  wire done   = tick && mdc_q && bitn == 6'd63;
  wire unused_wbits = ^wdata[31:27];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; rvalid <= 1'b0; rd_op <= 1'b0;
      phy <= '0; regn <= '0; data <= '0; sh <= '0;
      bitn <= '0; cnt <= '0; mdc_q <= 1'b0; smp <= 1'b0;
    end else if (cmd_go) begin
      busy   <= 1'b1;
      rvalid <= 1'b0;
      rd_op  <= wdata[26];
      phy    <= wdata[20:16];
      regn   <= wdata[25:21];
      data   <= wdata[15:0];
      sh     <= {32'hFFFF_FFFF, 2'b01, wdata[26] ? 2'b10 : 2'b01,
                 wdata[20:16], wdata[25:21], 2'b10, wdata[15:0]};
      bitn   <= '0;
      cnt    <= '0;
      mdc_q  <= 1'b0;
    end else if (busy) begin
      if (tick) begin
        cnt   <= '0;
        mdc_q <= ~mdc_q;
        if (!mdc_q) begin
          smp <= mdio_i;
        end else begin
          sh   <= {sh[62:0], smp};
          bitn <= bitn + 6'd1;
          if (bitn == 6'd63) begin
            busy <= 1'b0;
            if (rd_op) begin
              rvalid <= 1'b1;
              data   <= {sh[14:0], smp};
            end
          end
        end
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause <= 1'b0;
      mask  <= 1'b0;
    end else begin
      if (done) cause <= 1'b1;
      else if (wr_en && addr == OFS_CAUSE) cause <= cause & wdata[4];
      if (wr_en && addr == OFS_MASK) mask <= wdata[4];
    end
  end

  assign mdc     = mdc_q;
  assign mdio_o  = sh[63];
  assign mdio_oe = busy && (!rd_op || bitn < 6'd46);
  assign irq     = cause && mask;

  always_comb begin
    rdata = '0;
    if (addr == OFS_CMD)
      rdata = {3'b000, busy, rvalid, rd_op, regn, phy, data};
    else if (addr == OFS_CAUSE)
      rdata[4] = cause;
    else if (addr == OFS_MASK)
      rdata[4] = mask;
  end
endmodule

// File: rtl/mdio_cmd_master_chk.sv
module mdio_cmd_master_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic          busy,
  input logic          rvalid,
  input logic          rd_op,
  input logic [4:0]    phy,
  input logic [4:0]    regn,
  input logic          cause,
  input logic          mdc,
  input logic          mdio_oe
);
  a_r2_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_en && addr == '0) |=> (busy && !rvalid));

  a_r6_busy_ignores_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && addr == '0) |=> ($stable(phy) && $stable(regn) && $stable(rd_op)));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  a_r8_cause_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> cause);

  a_r4_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rvalid) |-> (rd_op && !busy));
endmodule

bind mdio_cmd_master mdio_cmd_master_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .busy(busy),
  .rvalid(rvalid), .rd_op(rd_op), .phy(phy), .regn(regn), .cause(cause),
  .mdc(mdc), .mdio_oe(mdio_oe)
);

// File: tb/mdio_cmd_master_tb.sv
`timescale 1ns/1ps
module mdio_cmd_master_tb;
  localparam int D = 4;
  localparam int FRAME = 128 * D;

  logic clk = 0, rst_n = 0, wr_en = 0, mdio_i;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic mdc, mdio_o, mdio_oe, irq;
  int checks = 0, errors = 0;
  bit finished = 0;

  logic [63:0] cap;
  logic [15:0] phy_val;
  int idx;
  logic phy_drv;

  always #5 clk = ~clk;

  mdio_cmd_master #(.CLK_DIV(D), .AW(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i), .irq(irq));

  assign mdio_i = phy_drv;

  always @(posedge mdc) cap = {cap[62:0], mdio_oe ? mdio_o : mdio_i};
  always @(negedge mdc) begin
    idx = idx + 1;
    if (idx == 47) phy_drv = 1'b0;
    else if (idx >= 48 && idx <= 63) phy_drv = phy_val[63-idx];
    else phy_drv = 1'b1;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit rd, input logic [4:0] p,
                                     input logic [4:0] r, input logic [15:0] d);
    return {5'b0, rd, r, p, d};
  endfunction

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; addr = 0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata; addr = 0;
  endtask

  task automatic arm_phy(input logic [15:0] v);
    idx = 0; phy_drv = 1'b1; cap = '0; phy_val = v;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    addr = 0; #1;
    while (rdata[28]) begin @(negedge clk); n++; #1; end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 mdc/oe/irq", {mdc, mdio_oe, irq}, 3'b000);
    rd_reg(8'h00, v); chk("R1 cmd", v, 0);
    rd_reg(8'h7C, v); chk("R1 cause", v, 0);
    rd_reg(8'h80, v); chk("R1 mask", v, 0);
  endtask

  task automatic t_write_frame();
    logic [31:0] v; int n;
    arm_phy(16'h0);
    wr_reg(8'h00, mk(0, 5'h11, 5'h0A, 16'hBEEF));
    #1 chk("R2 busy set", rdata[28], 1);
    wait_idle(n);
    chk("R5 frame length", n, FRAME);
    chk("R3 write frame", cap, {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h11, 5'h0A, 2'b10, 16'hBEEF});
    rd_reg(8'h00, v);
    chk("R2 fields", v, mk(0, 5'h11, 5'h0A, 16'hBEEF));
    chk("R7 no valid after write", v[27], 0);
    chk("R10 idle pins", {mdc, mdio_oe}, 2'b00);
  endtask

  task automatic t_read_frame();
    logic [31:0] v; int n;
    wr_reg(8'h7C, 0);
    arm_phy(16'hA5C3);
    wr_reg(8'h00, mk(1, 5'h03, 5'h1F, 16'h0000));
    wait_idle(n);
    chk("R4 read frame", cap, {32'hFFFF_FFFF, 2'b01, 2'b10, 5'h03, 5'h1F, 2'b10, 16'hA5C3});
    rd_reg(8'h00, v);
    chk("R4 read data", v[15:0], 16'hA5C3);
    chk("R4 read valid", v[27], 1);
    rd_reg(8'h7C, v);
    chk("R8 cause set", v[4], 1);
    arm_phy(16'h0);
    wr_reg(8'h00, mk(0, 5'h01, 5'h01, 16'h1234));
    rd_reg(8'h00, v);
    chk("R7 valid cleared by new cmd", v[27], 0);
    wait_idle(n);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v; int n;
    arm_phy(16'h5555);
    wr_reg(8'h00, mk(0, 5'h07, 5'h02, 16'hC001));
    repeat (20) @(negedge clk);
    wr_reg(8'h00, mk(1, 5'h18, 5'h1C, 16'hFFFF));
    wait_idle(n);
    chk("R6 frame unchanged", cap, {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h07, 5'h02, 2'b10, 16'hC001});
    rd_reg(8'h00, v);
    chk("R6 fields unchanged", v, mk(0, 5'h07, 5'h02, 16'hC001));
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr_reg(8'h80, 32'h10);
    #1 chk("R9 irq with mask", irq, 1);
    wr_reg(8'h7C, 32'hFFFF_FFFF);
    rd_reg(8'h7C, v); chk("R8 write one keeps", v[4], 1);
    wr_reg(8'h80, 32'h0);
    #1 chk("R9 masked irq", irq, 0);
    wr_reg(8'h80, 32'h10);
    wr_reg(8'h7C, 32'hFFFF_FFEF);
    rd_reg(8'h7C, v); chk("R8 write zero clears", v[4], 0);
    #1 chk("R9 irq follows cause", irq, 0);
  endtask

  task automatic t_collision();
    logic [31:0] v;
    arm_phy(16'h0);
    wr_reg(8'h00, mk(0, 5'h02, 5'h03, 16'h0F0F));
    repeat (FRAME - 1) @(negedge clk);
    wr_en = 1; addr = 8'h7C; wdata = 0;
    @(negedge clk); wr_en = 0; addr = 0;
    rd_reg(8'h00, v); chk("R5 idle at collision", v[28], 0);
    rd_reg(8'h7C, v); chk("R8 set wins over clear", v[4], 1);
    #1 chk("R9 irq after collision", irq, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_write_frame();
    t_read_frame();
    t_busy_ignore();
    t_irq();
    t_collision();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule